// File: doc/BRIEF.md
# Three-Level Memory and Peripheral Address Decoder

This block turns the 16-bit address of an 8-bit microprocessor bus into chip enables for two ROMs and one RAM, and into strobes for the peripheral registers of an instrument controller. The map is fixed. The top five address bits sort every access into one of thirty-two 2K-byte blocks. Low memory goes to RAM. The upper half goes to ROM, and bit 14 picks which ROM. One 2K-byte block carries the peripherals.

Inside the peripheral block a second level splits the space into 64-byte regions, and the last of those regions goes to a third level of single-address strobes. The 512-byte peripheral window repeats four times across its 2K block. The 16-address single window repeats four times across its 64-byte region.

Three bank-mode inputs can move RAM over the lowest 8K of ROM space. Every output is active-high and combinational. No output asserts unless the valid-memory-address flag and the bus enable phase are both high.

Top module: `scope_addr_decode`

## Requirements
- R1: For 0x0000–0x07FF, ram_oe_o asserts when rw_i=1 (read) and ram_we_o asserts when rw_i=0 (write).
- R2: With all bank inputs low, a read in 0x8000–0xFFFF asserts rom_cs_o[0] when addr bit 14 is 0, and rom_cs_o[1] when it is 1. A write in that range asserts no output.
- R3: When any bit of bank_i is high, 0x8000–0x9FFF behaves as RAM under the same read/write rule as R1, and neither ROM select asserts there. 0xA000–0xFFFF still follows R2.
- R4: Addresses 0x1000–0x7FFF assert no output.
- R5: In 0x0800–0x0FFF, with address bits 10:9 ignored, offset bits 8:6 equal to k (k = 0..6) assert region_stb_o[k]. This happens for both reads and writes.
- R6: In 0x0800–0x0FFF, when address bits 8:6 are 7 and bits 10:9 and 5:4 are ignored, address bits 3:0 equal to n assert single_stb_o[n]. This happens for both reads and writes.
- R7: Every output is low unless vma_i and e_i are both high.
- R8: At most one bit of {region_stb_o, single_stb_o} is high at a time. At most one of {rom_cs_o, ram_oe_o, ram_we_o} is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 16 | Processor address bus |
| vma_i | input | 1 | Valid memory address flag |
| e_i | input | 1 | Bus enable phase |
| rw_i | input | 1 | 1 = read, 0 = write |
| bank_i | input | 3 | Bank-mode inputs; any high maps RAM over low ROM space |
| rom_cs_o | output | 2 | One-hot ROM selects |
| ram_oe_o | output | 1 | RAM output enable |
| ram_we_o | output | 1 | RAM write enable |
| region_stb_o | output | 7 | One-hot 64-byte peripheral region strobes |
| single_stb_o | output | 16 | One-hot single-address peripheral strobes |

## Verification
The bench builds the decoder with its default parameters: a 16-bit address, two ROMs, three bank inputs, eight regions and sixteen single strobes. With these values the address space is small enough to sweep in full. Every one of the 65536 addresses is driven for reads and writes, once with no bank input high and once with each bank input alone. This reaches every block boundary, every mirror copy and the edges of the bank overlay. A sparser sweep with vma_i or e_i low covers the qualification rule.

// File: rtl/scope_addr_dec_pkg.sv
package scope_addr_dec_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned BLK_W    = 5;
  localparam int unsigned ROM_N    = 2;
  localparam int unsigned BANK_N   = 3;
  localparam int unsigned REGION_N = 8;
  localparam int unsigned REGION_W = 6;
  localparam int unsigned SINGLE_N = 16;

  typedef enum logic [1:0] {
    BLK_NONE = 2'd0,
    BLK_RAM  = 2'd1,
    BLK_IO   = 2'd2,
    BLK_ROM  = 2'd3
  } blk_kind_e;
endpackage

// File: rtl/addr_blk_decode.sv
module addr_blk_decode
  import scope_addr_dec_pkg::*;
#(
  parameter int unsigned BLK_BITS = BLK_W,
  parameter int unsigned ROMS     = ROM_N,
  parameter int unsigned BANKS    = BANK_N
) (
  input  logic [BLK_BITS-1:0] blk_i,
  input  logic [BANKS-1:0]    bank_i,
  input  logic                qual_i,
  input  logic                rw_i,
  output logic [ROMS-1:0]     rom_cs_o,
  output logic                ram_oe_o,
  output logic                ram_we_o,
  output logic                io_en_o
);
  localparam int unsigned ROM_IDX_W = (ROMS > 1) ? $clog2(ROMS) : 1;

  blk_kind_e kind;
  logic      overlay;
  logic [ROM_IDX_W-1:0] rom_idx;

  // 8000-9FFF is the lowest quarter of ROM space: top three block bits 100
  assign overlay = (|bank_i) && (blk_i[BLK_BITS-1 -: 3] == 3'b100);
  assign rom_idx = blk_i[BLK_BITS-2 -: ROM_IDX_W];

  always_comb begin
    if (blk_i[BLK_BITS-1])          kind = overlay ? BLK_RAM : BLK_ROM;
    else if (blk_i == '0)           kind = BLK_RAM;
    else if (blk_i == BLK_BITS'(1)) kind = BLK_IO;
    else                            kind = BLK_NONE;
  end

  assign ram_oe_o = qual_i && (kind == BLK_RAM) && rw_i;
  assign ram_we_o = qual_i && (kind == BLK_RAM) && !rw_i;
  assign io_en_o  = qual_i && (kind == BLK_IO);

  for (genvar g = 0; g < ROMS; g++) begin : g_rom
    assign rom_cs_o[g] = qual_i && rw_i && (kind == BLK_ROM) &&
                         (rom_idx == ROM_IDX_W'(g));
  end
endmodule

// File: rtl/addr_region_decode.sv
module addr_region_decode
  import scope_addr_dec_pkg::*;
#(
  parameter int unsigned REGIONS = REGION_N,
  parameter int unsigned RW      = REGION_W
) (
  input  logic [$clog2(REGIONS)+RW-1:0] off_i,
  input  logic                          en_i,
  output logic [REGIONS-2:0]            stb_o,
  output logic                          sub_en_o
);
  localparam int unsigned IDX_W = $clog2(REGIONS);

  logic [IDX_W-1:0] idx;
  assign idx = off_i[RW +: IDX_W];

  for (genvar g = 0; g < REGIONS - 1; g++) begin : g_reg
    assign stb_o[g] = en_i && (idx == IDX_W'(g));
  end
  // last region hands off to the single-address level
  assign sub_en_o = en_i && (idx == IDX_W'(REGIONS - 1));
endmodule

// File: rtl/addr_single_decode.sv
module addr_single_decode
  import scope_addr_dec_pkg::*;
#(
  parameter int unsigned SINGLES = SINGLE_N
) (
  input  logic [$clog2(SINGLES)-1:0] idx_i,
  input  logic                       en_i,
  output logic [SINGLES-1:0]         stb_o
);
  localparam int unsigned IDX_W = $clog2(SINGLES);

  for (genvar g = 0; g < SINGLES; g++) begin : g_sng
    assign stb_o[g] = en_i && (idx_i == IDX_W'(g));
  end
endmodule

// File: rtl/scope_addr_decode.sv
module scope_addr_decode
  import scope_addr_dec_pkg::*;
#(
  parameter int unsigned AW      = ADDR_W,
  parameter int unsigned ROMS    = ROM_N,
  parameter int unsigned BANKS   = BANK_N,
  parameter int unsigned REGIONS = REGION_N,
  parameter int unsigned SINGLES = SINGLE_N
) (
  input  logic [AW-1:0]      addr_i,
  input  logic               vma_i,
  input  logic               e_i,
  input  logic               rw_i,
  input  logic [BANKS-1:0]   bank_i,
  output logic [ROMS-1:0]    rom_cs_o,
  output logic               ram_oe_o,
  output logic               ram_we_o,
  output logic [REGIONS-2:0] region_stb_o,
  output logic [SINGLES-1:0] single_stb_o
);
  localparam int unsigned OFF_W = $clog2(REGIONS) + REGION_W;
  localparam int unsigned SIX_W = $clog2(SINGLES);

  logic qual, io_en, sub_en;
  assign qual = vma_i && e_i;

  addr_blk_decode #(.BLK_BITS(BLK_W), .ROMS(ROMS), .BANKS(BANKS)) u_blk (
    .blk_i    (addr_i[AW-1 -: BLK_W]),
    .bank_i   (bank_i),
    .qual_i   (qual),
    .rw_i     (rw_i),
    .rom_cs_o (rom_cs_o),
    .ram_oe_o (ram_oe_o),
    .ram_we_o (ram_we_o),
    .io_en_o  (io_en)
  );

  // bits between OFF_W and the block field are dropped: mirrors
  addr_region_decode #(.REGIONS(REGIONS), .RW(REGION_W)) u_region (
    .off_i    (addr_i[OFF_W-1:0]),
    .en_i     (io_en),
    .stb_o    (region_stb_o),
    .sub_en_o (sub_en)
  );

  addr_single_decode #(.SINGLES(SINGLES)) u_single (
    .idx_i (addr_i[SIX_W-1:0]),
    .en_i  (sub_en),
    .stb_o (single_stb_o)
  );
endmodule

// File: rtl/scope_addr_decode_chk.sv
module scope_addr_decode_chk (
  input logic [15:0] addr_i,
  input logic        vma_i,
  input logic        e_i,
  input logic        rw_i,
  input logic [2:0]  bank_i,
  input logic [1:0]  rom_cs_o,
  input logic        ram_oe_o,
  input logic        ram_we_o,
  input logic [6:0]  region_stb_o,
  input logic [15:0] single_stb_o
);
  logic any_out;
  assign any_out = |{rom_cs_o, ram_oe_o, ram_we_o, region_stb_o, single_stb_o};

  always_comb begin
    // R7
    gate_chk: assert (vma_i && e_i || !any_out);
    // R8
    stb_onehot_chk: assert ($onehot0({region_stb_o, single_stb_o}));
    // R8
    mem_onehot_chk: assert ($onehot0({rom_cs_o, ram_oe_o, ram_we_o}));
    // R3
    bank_rom_chk: assert (!((|bank_i) && addr_i >= 16'h8000 && addr_i < 16'hA000) || rom_cs_o == 2'b00);
    // R2
    rom_read_chk: assert (rom_cs_o == 2'b00 || (rw_i && addr_i[15]));
    // R1
    ram_we_chk: assert (!ram_we_o || !rw_i);
    // R4
    reserved_chk: assert (!(addr_i >= 16'h1000 && addr_i < 16'h8000) || !any_out);
    // R6
    single_win_chk: assert (single_stb_o == '0 || (addr_i[15:11] == 5'b00001 && addr_i[8:6] == 3'b111));
  end
endmodule

bind scope_addr_decode scope_addr_decode_chk u_chk (
  .addr_i       (addr_i),
  .vma_i        (vma_i),
  .e_i          (e_i),
  .rw_i         (rw_i),
  .bank_i       (bank_i),
  .rom_cs_o     (rom_cs_o),
  .ram_oe_o     (ram_oe_o),
  .ram_we_o     (ram_we_o),
  .region_stb_o (region_stb_o),
  .single_stb_o (single_stb_o)
);

// File: tb/scope_addr_decode_tb.sv
`timescale 1ns/100ps
module scope_addr_decode_tb;
  typedef struct {
    logic [26:0] bits;
    logic [15:0] addr;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        vma_i = 1'b0, e_i = 1'b0, rw_i = 1'b1;
  logic [2:0]  bank_i = '0;
  logic [1:0]  rom_cs_o;
  logic        ram_oe_o, ram_we_o;
  logic [6:0]  region_stb_o;
  logic [15:0] single_stb_o;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  scope_addr_decode u_dut (
    .addr_i(addr_i), .vma_i(vma_i), .e_i(e_i), .rw_i(rw_i), .bank_i(bank_i),
    .rom_cs_o(rom_cs_o), .ram_oe_o(ram_oe_o), .ram_we_o(ram_we_o),
    .region_stb_o(region_stb_o), .single_stb_o(single_stb_o)
  );

  function automatic exp_t model(logic [15:0] a, logic v, logic e, logic rw, logic [2:0] bk);
    exp_t r;
    logic q, ram, rom;
    logic [1:0] rs = '0;
    logic [6:0] rg = '0;
    logic [15:0] sg = '0;
    int off;
    q   = v && e;
    ram = (a < 16'h0800) || (bk != 0 && a >= 16'h8000 && a < 16'hA000);
    rom = (a >= 16'h8000) && !ram;
    if (q && rw && rom) rs = (a < 16'hC000) ? 2'b01 : 2'b10;
    if (q && a >= 16'h0800 && a < 16'h1000) begin
      off = (int'(a) - 'h800) % 'h200;
      if (off < 'h1C0) rg[off / 64] = 1'b1;
      else             sg[off % 16] = 1'b1;
    end
    r.bits = {rs, q && ram && rw, q && ram && !rw, rg, sg};
    r.addr = a;
    if (!q)                                   r.tag = "R7";
    else if (a < 16'h0800)                    r.tag = "R1";
    else if (a < 16'h1000)                    r.tag = (((int'(a) - 'h800) % 'h200) < 'h1C0) ? "R5" : "R6";
    else if (a < 16'h8000)                    r.tag = "R4";
    else if (bk != 0 && a < 16'hA000)         r.tag = "R3";
    else                                      r.tag = "R2";
    return r;
  endfunction

  task automatic drive(logic [15:0] a, logic v, logic e, logic rw, logic [2:0] bk);
    addr_i = a; vma_i = v; e_i = e; rw_i = rw; bank_i = bk;
    exp_q.push_back(model(a, v, e, rw, bk));
    #1;
  endtask

  // monitor: samples half a step after each drive
  initial begin
    #0.5;
    forever begin
      if (exp_q.size() > 0) begin
        exp_t x;
        logic [26:0] got;
        x   = exp_q.pop_front();
        got = {rom_cs_o, ram_oe_o, ram_we_o, region_stb_o, single_stb_o};
        checks++;
        if (got !== x.bits) begin
          errors++;
          $display("FAIL %s addr=%h actual=%h expected=%h", x.tag, x.addr, got, x.bits);
        end
      end
      #1;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] banks [4];
    banks[0] = 3'b000; banks[1] = 3'b001; banks[2] = 3'b010; banks[3] = 3'b100;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset state: idle bus, R7
    drive(16'h0000, 1'b0, 1'b0, 1'b1, 3'b000);
    // corner points: R1..R6
    drive(16'h07FF, 1'b1, 1'b1, 1'b0, 3'b000);  // R1 write
    drive(16'h0800, 1'b1, 1'b1, 1'b0, 3'b000);  // R5 region 0
    drive(16'h0E7F, 1'b1, 1'b1, 1'b1, 3'b000);  // R5 mirror, region 1
    drive(16'h0FFF, 1'b1, 1'b1, 1'b0, 3'b000);  // R6 mirror, strobe 15
    drive(16'h09D3, 1'b1, 1'b1, 1'b1, 3'b000);  // R6 mirror, strobe 3
    drive(16'h1000, 1'b1, 1'b1, 1'b1, 3'b000);  // R4
    drive(16'h9FFF, 1'b1, 1'b1, 1'b1, 3'b010);  // R3
    drive(16'hA000, 1'b1, 1'b1, 1'b1, 3'b100);  // R3 edge, ROM 0
    drive(16'hC000, 1'b1, 1'b1, 1'b1, 3'b000);  // R2 ROM 1
    drive(16'hBFFF, 1'b1, 1'b1, 1'b0, 3'b000);  // R2 write to ROM
    // full sweep: R1-R6 and R8 via one-hot expectation
    for (int b = 0; b < 4; b++)
      for (int rw = 0; rw < 2; rw++)
        for (int a = 0; a < 65536; a++)
          drive(16'(a), 1'b1, 1'b1, rw[0], banks[b]);
    // qualification sweep: R7
    for (int a = 0; a < 65536; a += 61) begin
      drive(16'(a), 1'b0, 1'b1, a[0], 3'b001);
      drive(16'(a), 1'b1, 1'b0, a[1], 3'b000);
    end
    #3;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule